// File: doc/BRIEF.md
# Multi-Supply Time-Position Sequencer

This controller powers up to four supply channels in a fixed order of time slots when a global run input goes high, and powers them down in the opposite order when it goes low. Each channel is given a slot code from 1 to 8. The block walks through the slots one at a time, spending at least one programmable step delay on each slot. Before the next slot is served, every channel switched on in the previous slot must report that it has crossed its sequence-up threshold. Power-down replays the slots from 8 down to 1. Here each slot waits for the channels switched off in the previous step to report that they have fallen below their sequence-down threshold.

A power-good watchdog covers each whole ramp. It starts at the first channel switched on (or off) and runs until the ramp completes and every configured channel has settled. If it expires, the block latches a sequence fault and the lowest-numbered failing channel. It then drops all enables and holds them low until the run input is taken low. A separate system-fault input drops every enable in one cycle. While the run input is low and the block is idle, a force mask can switch on chosen channels directly so that supplies can be tested one at a time or in any combination. Timers are counted in clock cycles. The configuration inputs are assumed to stay static while a ramp is in progress.

Top module: `supply_sequencer`

## Requirements
- R1: A channel whose 4-bit slot field (bits 4i+3..4i of `ch_slot` for channel i) holds 0 or a value above 8 is never enabled, whether by sequencing or by the force mask.
- R2: While the block is idle with `seq_on` low, each configured channel whose `ch_force` bit is set has its enable high one cycle later. All forced enables are cleared on the cycle that sequencing up begins.
- R3: The first slot acts `step_cycles` clock edges after the edge that registers `seq_on` high. Each later slot acts at least `step_cycles` edges after the one before it. A `step_cycles` value of 0 behaves like 1.
- R4: The gap after a slot stretches until every channel switched on in that slot shows `up_ok`. Only then is the step delay counted.
- R5: When `seq_on` falls, channels are disabled from slot 8 down to slot 1, with the same step-delay rule. Each step waits on the `down_ok` flags of the channels disabled in the step before.
- R6: If the power-good watchdog reaches `wdog_cycles` before the ramp settles, `seq_fault` rises. A `wdog_cycles` of 0 never raises a fault.
- R7: While `sys_fault` is high, all enables are low from the next clock edge onward, and the block ignores `seq_on` until both `sys_fault` and `seq_on` have been low.
- R8: `seq_done` rises one edge after the last slot has acted and every configured channel shows `uv_ok`. It falls on the edge that registers `seq_on` low.
- R9: On a sequence fault, `fault_ch` holds the lowest-index failing channel and all enables stay low until `seq_on` is low, which also clears `seq_fault`.
- R10: Channels that share a slot code are enabled in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_on | input | 1 | Run request: high ramps up, low ramps down |
| sys_fault | input | 1 | Immediate shutdown request |
| step_cycles | input | STEP_W | Minimum cycles per slot |
| wdog_cycles | input | WDOG_W | Power-good watchdog limit, 0 disables it |
| ch_slot | input | 4*NUM_CH | Slot code per channel, 4 bits each |
| ch_force | input | NUM_CH | Force-on mask used while idle |
| up_ok | input | NUM_CH | Channel above its sequence-up threshold |
| down_ok | input | NUM_CH | Channel below its sequence-down threshold |
| uv_ok | input | NUM_CH | Channel above its undervoltage threshold |
| ch_en | output | NUM_CH | Per-channel enable |
| seq_done | output | 1 | Ramp up complete and all supplies good |
| seq_fault | output | 1 | Latched sequence fault |
| fault_ch | output | CH_W | Index of the first failing channel |

## Verification
The in-RTL assertions check four things on every cycle:
- An unconfigured channel never carries an enable.
- A system fault clears every enable at the next edge.
- A latched fault never coexists with an enable.
- `seq_done` drops once the run input is low, and a fault can only rise while the watchdog limit is nonzero.

The minimum step gap is also asserted whenever the step setting is larger than one. Only the bench's scenarios can show the exact cycle at which each slot acts, and the stretching caused by slow supplies. They also show that power-down mirrors power-up, which channel a watchdog fault reports, and the behaviour of the force mask.

// File: rtl/sqs_pkg.sv
// Package: shared types and constants for the supply sequencer.
// Assumes slot codes are 4 bits wide, with 1..8 the only valid positions.
package sqs_pkg;
    localparam int SLOT_W   = 4;
    localparam int POS_LAST = 8;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_UP_RAMP,
        SQ_UP_SETTLE,
        SQ_ON,
        SQ_DN_RAMP,
        SQ_DN_SETTLE,
        SQ_HALT
    } sq_state_e;
endpackage

// File: rtl/sqs_slot_match.sv
// Module: decodes every channel's slot field against a position value.
// Assumes slot fields are packed 4 bits per channel, channel 0 lowest.
// Outputs: hit marks channels at that position, cfg marks channels with a valid slot.
module sqs_slot_match #(
    parameter int NUM_CH = 4
) (
    input  logic [sqs_pkg::SLOT_W*NUM_CH-1:0] slots,
    input  logic [sqs_pkg::SLOT_W-1:0]        pos,
    output logic [NUM_CH-1:0]                 hit,
    output logic [NUM_CH-1:0]                 cfg
);
    localparam int SW = sqs_pkg::SLOT_W;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [SW-1:0] code;
        // Per-channel decode of the slot field.
        assign code   = slots[g*SW +: SW];
        assign cfg[g] = (code != '0) && (code <= SW'(sqs_pkg::POS_LAST));
        assign hit[g] = cfg[g] && (code == pos);
    end
endmodule

// File: rtl/sqs_step_timer.sv
// Module: minimum step-delay counter gated by a readiness condition.
// Assumes run is high only during a ramp. The count holds at zero while the
// gate is low, so the delay is counted only after the gate opens.
module sqs_step_timer #(
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              gate_ok,
    input  logic [STEP_W-1:0] step_cycles,
    output logic              fire
);
    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign fire    = run && gate_ok && (cnt_inc >= {1'b0, step_cycles});

    // Count gated cycles since the last step; restart on step or gate loss.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || !gate_ok || fire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Two steps never come back to back when the step setting exceeds one.
    assert_step_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && step_cycles > STEP_W'(1)) |=> (!fire || step_cycles != $past(step_cycles)));
endmodule

// File: rtl/sqs_pg_watchdog.sv
// Module: power-good watchdog spanning one ramp.
// Assumes clear is high whenever no ramp is in progress. Arming happens on the
// first supply action of the ramp. A zero limit never times out.
module sqs_pg_watchdog #(
    parameter int WDOG_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              arm,
    input  logic [WDOG_W-1:0] limit,
    output logic              timeout
);
    logic              armed_q;
    logic [WDOG_W-1:0] cnt_q;

    assign timeout = armed_q && (limit != '0) && (cnt_q >= limit);

    // Arm on the first action, then count cycles until the ramp is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (arm && !armed_q) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (armed_q && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/supply_sequencer.sv
// Module: top-level sequencer for up to NUM_CH supplies across eight time slots.
// Assumes slot codes, force mask and timer settings are static during a ramp,
// and that threshold flags are already synchronous to clk.
module supply_sequencer #(
    parameter  int NUM_CH = 4,
    parameter  int STEP_W = 16,
    parameter  int WDOG_W = 20,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              seq_on,
    input  logic                              sys_fault,
    input  logic [STEP_W-1:0]                 step_cycles,
    input  logic [WDOG_W-1:0]                 wdog_cycles,
    input  logic [sqs_pkg::SLOT_W*NUM_CH-1:0] ch_slot,
    input  logic [NUM_CH-1:0]                 ch_force,
    input  logic [NUM_CH-1:0]                 up_ok,
    input  logic [NUM_CH-1:0]                 down_ok,
    input  logic [NUM_CH-1:0]                 uv_ok,
    output logic [NUM_CH-1:0]                 ch_en,
    output logic                              seq_done,
    output logic                              seq_fault,
    output logic [CH_W-1:0]                   fault_ch
);
    import sqs_pkg::*;

    localparam logic [SLOT_W-1:0] POS_TOP = SLOT_W'(POS_LAST + 1);

    sq_state_e         state_q;
    logic [SLOT_W-1:0] pos_q, pos_nxt;
    logic [NUM_CH-1:0] en_q, hit_cur, hit_nxt, cfg, cfg_unused, cand;
    logic              fault_q;
    logic [CH_W-1:0]   fault_ch_q, pick;
    logic              in_up, in_dn, dn_phase, ramp_phase;
    logic              gate_up, gate_dn, fire, wd_clear, wd_arm, timeout;
    logic              all_uv, all_dn;

    assign in_up      = (state_q == SQ_UP_RAMP);
    assign in_dn      = (state_q == SQ_DN_RAMP);
    assign dn_phase   = in_dn || (state_q == SQ_DN_SETTLE);
    assign ramp_phase = in_up || in_dn || (state_q == SQ_UP_SETTLE) || (state_q == SQ_DN_SETTLE);
    assign pos_nxt    = in_dn ? (pos_q - 1'b1) : (pos_q + 1'b1);

    // Channels sitting at the last served slot (the gate) and at the next slot (the action).
    sqs_slot_match #(.NUM_CH(NUM_CH)) u_match_cur (
        .slots(ch_slot), .pos(pos_q),   .hit(hit_cur), .cfg(cfg));
    sqs_slot_match #(.NUM_CH(NUM_CH)) u_match_nxt (
        .slots(ch_slot), .pos(pos_nxt), .hit(hit_nxt), .cfg(cfg_unused));

    assign gate_up = &(~hit_cur | up_ok);
    assign gate_dn = &(~hit_cur | down_ok);
    assign all_uv  = &(~cfg | uv_ok);
    assign all_dn  = &(~cfg | down_ok);

    sqs_step_timer #(.STEP_W(STEP_W)) u_step (
        .clk(clk), .rst_n(rst_n), .run(in_up || in_dn),
        .gate_ok(in_dn ? gate_dn : gate_up),
        .step_cycles(step_cycles), .fire(fire));

    assign wd_arm   = fire && (|hit_nxt);
    assign wd_clear = !ramp_phase || (!dn_phase && !seq_on);

    sqs_pg_watchdog #(.WDOG_W(WDOG_W)) u_wdog (
        .clk(clk), .rst_n(rst_n), .clear(wd_clear), .arm(wd_arm),
        .limit(wdog_cycles), .timeout(timeout));

    // Failing-channel candidates for the current ramp direction.
    assign cand = dn_phase ? (cfg & ~en_q & ~down_ok) : (cfg & en_q & ~uv_ok);

    // Choose the lowest-index candidate.
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--)
            if (cand[i]) pick = CH_W'(i);
    end

    // Main sequencing state machine with its enable and fault registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_OFF;
            pos_q      <= '0;
            en_q       <= '0;
            fault_q    <= 1'b0;
            fault_ch_q <= '0;
        end else if (sys_fault) begin
            state_q <= SQ_HALT;
            en_q    <= '0;
        end else begin
            case (state_q)
                SQ_OFF: begin
                    if (seq_on) begin
                        state_q <= SQ_UP_RAMP;
                        pos_q   <= '0;
                        en_q    <= '0;
                    end else begin
                        en_q <= ch_force & cfg;
                    end
                end
                SQ_UP_RAMP, SQ_UP_SETTLE: begin
                    if (!seq_on) begin
                        state_q <= SQ_DN_RAMP;
                        pos_q   <= POS_TOP;
                    end else if (state_q == SQ_UP_SETTLE && all_uv) begin
                        state_q <= SQ_ON;
                    end else if (timeout) begin
                        state_q    <= SQ_HALT;
                        en_q       <= '0;
                        fault_q    <= 1'b1;
                        fault_ch_q <= pick;
                    end else if (in_up && fire) begin
                        en_q  <= en_q | hit_nxt;
                        pos_q <= pos_nxt;
                        if (pos_nxt == SLOT_W'(POS_LAST)) state_q <= SQ_UP_SETTLE;
                    end
                end
                SQ_ON: begin
                    if (!seq_on) begin
                        state_q <= SQ_DN_RAMP;
                        pos_q   <= POS_TOP;
                    end
                end
                SQ_DN_RAMP, SQ_DN_SETTLE: begin
                    if (state_q == SQ_DN_SETTLE && all_dn) begin
                        state_q <= SQ_OFF;
                    end else if (timeout) begin
                        state_q    <= SQ_HALT;
                        en_q       <= '0;
                        fault_q    <= 1'b1;
                        fault_ch_q <= pick;
                    end else if (in_dn && fire) begin
                        en_q  <= en_q & ~hit_nxt;
                        pos_q <= pos_nxt;
                        if (pos_nxt == SLOT_W'(1)) state_q <= SQ_DN_SETTLE;
                    end
                end
                default: begin
                    en_q <= '0;
                    if (!seq_on) begin
                        state_q <= SQ_OFF;
                        fault_q <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign ch_en     = en_q;
    assign seq_done  = (state_q == SQ_ON);
    assign seq_fault = fault_q;
    assign fault_ch  = fault_ch_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg_chk
        // An unconfigured channel stays dark.
        assert_unslotted_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[g] |=> !ch_en[g]);
    end

    assert_kill_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_fault |=> (ch_en == '0));

    assert_fault_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fault |-> (ch_en == '0));

    assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !seq_on) |=> !seq_done);

    assert_wd_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_fault) |-> ($past(wdog_cycles) != '0));
endmodule

// File: tb/supply_sequencer_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected enable changes (value and clock edge), plus
// direct checks for the force, fault and shutdown scenarios.
module supply_sequencer_bench;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seq_on = 1'b0;
    logic          sys_fault = 1'b0;
    logic [15:0]   step_cycles = 16'd4;
    logic [19:0]   wdog_cycles = 20'd1000;
    logic [4*N-1:0] ch_slot = '0;
    logic [N-1:0]  ch_force = '0;
    logic [N-1:0]  up_ok = '0, down_ok = '0, uv_ok = '0;
    logic [N-1:0]  ch_en;
    logic          seq_done, seq_fault;
    logic [1:0]    fault_ch;

    supply_sequencer u_supply_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_on(seq_on), .sys_fault(sys_fault),
        .step_cycles(step_cycles), .wdog_cycles(wdog_cycles),
        .ch_slot(ch_slot), .ch_force(ch_force), .up_ok(up_ok),
        .down_ok(down_ok), .uv_ok(uv_ok), .ch_en(ch_en),
        .seq_done(seq_done), .seq_fault(seq_fault), .fault_ch(fault_ch));

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int base = 0;
    int rise_t [N] = '{6, 3, 3, 3};
    int lvl    [N] = '{0, 0, 0, 0};
    logic [N-1:0] stuck = '0;
    logic sb_on = 1'b0;

    typedef struct {
        logic [N-1:0] en;
        int           at;
        string        req;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_en(input logic [N-1:0] v, input int k, input string req);
        exp_t it;
        it.en = v;
        it.at = base + 1 + k;
        it.req = req;
        sbq.push_back(it);
    endtask

    task automatic wait_k(input int k);
        while (cyc < base + 1 + k) @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Edge counter.
    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Supply model: each channel ramps one level per cycle toward its rise time.
    initial forever begin
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (ch_en[i] && !stuck[i]) begin
                if (lvl[i] < rise_t[i]) lvl[i]++;
            end else if (!ch_en[i]) begin
                if (lvl[i] > 0) lvl[i]--;
            end
            up_ok[i]   = (lvl[i] >= rise_t[i]) && (lvl[i] != 0);
            uv_ok[i]   = (lvl[i] >= rise_t[i]) && (lvl[i] != 0);
            down_ok[i] = (lvl[i] == 0);
        end
    end

    // Monitor: every enable change is popped and compared against the scoreboard.
    initial begin
        logic [N-1:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            #0.1;
            if (sb_on && ch_en !== prev) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R5", "unexpected enable change", int'(ch_en), int'(prev));
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    check(ch_en === it.en, it.req, "enable value", int'(ch_en), int'(it.en));
                    check(cyc == it.at, it.req, "enable edge", cyc - base - 1, it.at - base - 1);
                end
            end
            prev = ch_en;
        end
    end

    // Watchdog on the run itself.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        check(ch_en == '0, "R8", "reset enables", int'(ch_en), 0);
        check(!seq_done, "R8", "reset done", int'(seq_done), 0);
        check(!seq_fault, "R9", "reset fault", int'(seq_fault), 0);

        // R1 / R2: force mask while idle; channel 1 has slot 0, so it is not forced.
        ch_slot = {4'd1, 4'd7, 4'd0, 4'd3};
        ch_force = 4'b0011;
        wait_n(2);
        check(ch_en == 4'b0001, "R2", "forced enables", int'(ch_en), 1);
        check(ch_en[1] == 1'b0, "R1", "slot 0 forced", int'(ch_en[1]), 0);
        ch_force = 4'b0000;
        wait_n(2);
        check(ch_en == '0, "R2", "force released", int'(ch_en), 0);

        // Main ramp: slots ch0=2, ch1=5, ch2=2, ch3=0 (forced but unslotted).
        ch_slot = {4'd0, 4'd2, 4'd5, 4'd2};
        ch_force = 4'b1000;
        step_cycles = 16'd4;
        wdog_cycles = 20'd1000;
        wait_n(2);
        sb_on = 1'b1;
        base = cyc;
        seq_on = 1'b1;
        expect_en(4'b0101, 8, "R10");
        expect_en(4'b0111, 25, "R4");
        wait_k(39);
        check(!seq_done, "R8", "done before settle", int'(seq_done), 0);
        wait_k(40);
        check(seq_done, "R8", "done after settle", int'(seq_done), 1);
        wait_n(3);
        base = cyc;
        seq_on = 1'b0;
        expect_en(4'b0101, 16, "R5");
        expect_en(4'b0000, 30, "R5");
        wait_k(0);
        check(!seq_done, "R8", "done on ramp down", int'(seq_done), 0);
        wait_k(46);
        check(ch_en == '0, "R1", "idle after ramp down, unslotted forced", int'(ch_en), 0);
        check(sbq.size() == 0, "R5", "scoreboard drained", sbq.size(), 0);

        // R3: step setting 0 behaves like 1.
        ch_force = '0;
        ch_slot = {4'd0, 4'd0, 4'd0, 4'd1};
        rise_t = '{1, 1, 1, 1};
        step_cycles = 16'd0;
        wait_n(2);
        base = cyc;
        seq_on = 1'b1;
        expect_en(4'b0001, 1, "R3");
        wait_k(20);
        base = cyc;
        seq_on = 1'b0;
        expect_en(4'b0000, 8, "R3");
        wait_k(20);
        check(sbq.size() == 0, "R3", "scoreboard drained", sbq.size(), 0);
        sb_on = 1'b0;

        // R6 / R9: channel 1 never comes up, so the watchdog expires.
        ch_slot = {4'd0, 4'd0, 4'd2, 4'd1};
        rise_t = '{6, 3, 3, 3};
        stuck = 4'b0010;
        step_cycles = 16'd2;
        wdog_cycles = 20'd30;
        wait_n(2);
        seq_on = 1'b1;
        wait_n(120);
        check(seq_fault, "R6", "watchdog fault", int'(seq_fault), 1);
        check(fault_ch == 2'd1, "R9", "fault channel", int'(fault_ch), 1);
        check(ch_en == '0, "R9", "enables held low", int'(ch_en), 0);
        seq_on = 1'b0;
        wait_n(3);
        check(!seq_fault, "R9", "fault cleared by run low", int'(seq_fault), 0);

        // R6: zero limit never faults; the stalled ramp keeps its enables.
        wdog_cycles = 20'd0;
        wait_n(10);
        seq_on = 1'b1;
        wait_n(150);
        check(!seq_fault, "R6", "zero limit fault", int'(seq_fault), 0);
        check(ch_en == 4'b0011, "R6", "stalled enables", int'(ch_en), 3);
        seq_on = 1'b0;
        wait_n(60);
        check(ch_en == '0, "R5", "ramp down from stall", int'(ch_en), 0);
        stuck = '0;

        // R7: system fault drops every enable at once.
        ch_slot = {4'd0, 4'd3, 4'd1, 4'd1};
        rise_t = '{2, 2, 2, 2};
        wdog_cycles = 20'd1000;
        wait_n(10);
        seq_on = 1'b1;
        wait_n(60);
        check(seq_done, "R8", "done before system fault", int'(seq_done), 1);
        check(ch_en == 4'b0111, "R10", "all up", int'(ch_en), 7);
        sys_fault = 1'b1;
        wait_n(1);
        check(ch_en == '0, "R7", "enables after system fault", int'(ch_en), 0);
        sys_fault = 1'b0;
        wait_n(5);
        check(ch_en == '0, "R7", "still halted with run high", int'(ch_en), 0);
        check(!seq_fault, "R7", "no sequence fault", int'(seq_fault), 0);
        seq_on = 1'b0;
        wait_n(5);
        seq_on = 1'b1;
        wait_n(60);
        check(seq_done, "R7", "restart after run cycled", int'(seq_done), 1);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule